// File: doc/BRIEF.md
# Configurable Registered Bus Buffer

This block is a clocked register stage placed on the address and command bus of a memory module. On every rising clock edge it samples a group of input bits and drives them out on a registered output bus. Two static strap inputs set its shape. In the default shape each of 25 inputs drives one output. In the fan-out shape 14 inputs each drive two outputs, and a second strap picks which 14 input positions feed the fan-out: the lower group or the upper group.

Two active-low chip-select inputs are sampled on every edge and passed through to registered chip-select outputs. When both are high at an edge, the data outputs keep their values, which saves switching power while the module is idle. Tying the secondary chip select low turns the hold off, and the primary chip select then acts as one more registered signal. An active-low reset, asynchronous to the clock, clears every register at once and overrides the hold.

Top module: `crb_buffer`

## Requirements
- R1: In direct mode (`fan_mode_i` low), `q_o[i]` equals `data_i[i]` for i in 0..24, taken at the rising edge and seen one clock cycle after the inputs are sampled.
- R2: In direct mode, output positions 25, 26 and 27 of `q_o` stay low.
- R3: In fan-out mode (`fan_mode_i` high) with `half_b_i` low, `q_o[i]` and `q_o[14+i]` both equal `data_i[i]` for i in 0..13.
- R4: In fan-out mode with `half_b_i` high, `q_o[i]` and `q_o[14+i]` both equal `data_i[11+i]` for i in 0..13.
- R5: When `cs_pri_ni` and `cs_sec_ni` are both high at a rising edge, `q_o` keeps the value it had before that edge.
- R6: When either chip select is low at a rising edge, `q_o` takes the newly mapped data at that edge.
- R7: `cs_pri_no` and `cs_sec_no` take the values of `cs_pri_ni` and `cs_sec_ni` at every rising edge, whether or not the data outputs are held.
- R8: Driving `rst_ni` low clears `q_o`, `cs_pri_no` and `cs_sec_no` to zero without waiting for a clock edge, even while both chip selects are high.
- R9: With `cs_sec_ni` tied low, `q_o` updates on every edge whatever the level of `cs_pri_ni`, and `cs_pri_no` follows `cs_pri_ni` like a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fan_mode_i | input | 1 | Strap: 0 selects 25-bit direct, 1 selects 14-bit fan-out |
| half_b_i | input | 1 | Strap: in fan-out mode 0 selects lower inputs, 1 selects upper inputs |
| cs_pri_ni | input | 1 | Primary chip select, active low |
| cs_sec_ni | input | 1 | Secondary chip select, active low |
| data_i | input | 25 | Address and command input bits |
| q_o | output | 28 | Registered data outputs |
| cs_pri_no | output | 1 | Registered primary chip select |
| cs_sec_no | output | 1 | Registered secondary chip select |

## Verification
A wrong mapping select or bit index shows on `q_o` at the first edge after data are applied, as a bit that disagrees with its source or as the two copies of a fan-out bit disagreeing with each other. A bad hold condition shows up on the next edge that has both chip selects high, or on one with only one of them high: the output either changes when it should freeze or freezes when it should move. A reset that waits for the clock or misses a register is seen within a few nanoseconds of `rst_ni` falling, before any edge arrives.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic [1:0] {
    MAP_DIRECT = 2'd0,
    MAP_LOW    = 2'd1,
    MAP_HIGH   = 2'd2
  } map_e;

  function automatic map_e decode_map(input logic fan_mode, input logic half_b);
    if (!fan_mode) return MAP_DIRECT;
    return half_b ? MAP_HIGH : MAP_LOW;
  endfunction
endpackage

// File: rtl/crb_map.sv
module crb_map
  import crb_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int FAN_W  = 14
) (
  input  map_e              map_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [2*FAN_W-1:0] mapped_o
);
  localparam int OUT_W  = 2 * FAN_W;
  localparam int HIGH_B = DATA_W - FAN_W;

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    localparam int J = i % FAN_W;
    logic direct_b;
    if (i < DATA_W) begin : g_used
      assign direct_b = data_i[i];
    end else begin : g_pad
      assign direct_b = 1'b0;
    end
    always_comb begin
      unique case (map_i)
        MAP_LOW:  mapped_o[i] = data_i[J];
        MAP_HIGH: mapped_o[i] = data_i[HIGH_B+J];
        default:  mapped_o[i] = direct_b;
      endcase
    end
  end
endmodule

// File: rtl/crb_gate.sv
module crb_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_pri_ni,
  input  logic cs_sec_ni,
  output logic upd_en_o,
  output logic cs_pri_no,
  output logic cs_sec_no
);
  // hold only when both selects are deasserted
  assign upd_en_o = ~(cs_pri_ni & cs_sec_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_pri_no <= 1'b0;
      cs_sec_no <= 1'b0;
    end else begin
      cs_pri_no <= cs_pri_ni;
      cs_sec_no <= cs_sec_ni;
    end
  end

  assert_cs_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cs_pri_no == $past(cs_pri_ni)) && (cs_sec_no == $past(cs_sec_ni)));
endmodule

// File: rtl/crb_outreg.sv
module crb_outreg #(
  parameter int OUT_W = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [OUT_W-1:0] d_i,
  output logic [OUT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (upd_en_i) q_o <= d_i;
  end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable(q_o));
  assert_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> q_o == $past(d_i));
endmodule

// File: rtl/crb_buffer.sv
module crb_buffer
  import crb_pkg::*;
#(
  parameter int DATA_W = 25,
  parameter int FAN_W  = 14,
  localparam int OUT_W = 2 * FAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fan_mode_i,
  input  logic              half_b_i,
  input  logic              cs_pri_ni,
  input  logic              cs_sec_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [OUT_W-1:0]  q_o,
  output logic              cs_pri_no,
  output logic              cs_sec_no
);
  localparam int PAD_W = OUT_W - DATA_W;

  map_e             map_sel;
  logic [OUT_W-1:0] mapped;
  logic             upd_en;

  assign map_sel = decode_map(fan_mode_i, half_b_i);

  crb_map #(.DATA_W(DATA_W), .FAN_W(FAN_W)) u_map (
    .map_i   (map_sel),
    .data_i  (data_i),
    .mapped_o(mapped)
  );

  crb_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_pri_ni(cs_pri_ni),
    .cs_sec_ni(cs_sec_ni),
    .upd_en_o (upd_en),
    .cs_pri_no(cs_pri_no),
    .cs_sec_no(cs_sec_no)
  );

  crb_outreg #(.OUT_W(OUT_W)) u_outreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_en_i(upd_en),
    .d_i     (mapped),
    .q_o     (q_o)
  );

  assert_direct_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fan_mode_i && upd_en) |=> q_o[DATA_W-1:0] == $past(data_i));
  assert_fan_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_mode_i && upd_en) |=> q_o[FAN_W +: FAN_W] == q_o[0 +: FAN_W]);
  assert_high_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_mode_i && half_b_i && upd_en) |=> q_o[0 +: FAN_W] == $past(data_i[DATA_W-1 -: FAN_W]));
  assert_sec_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_sec_ni |=> q_o == $past(mapped));

  if (PAD_W > 0) begin : g_pad_chk
    assert_pad_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fan_mode_i && upd_en) |=> q_o[OUT_W-1:DATA_W] == '0);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R8: assert (q_o == '0 && !cs_pri_no && !cs_sec_no);
  end
endmodule

// File: tb/crb_buffer_bench.sv
module crb_buffer_bench;
  localparam int DW = 25;
  localparam int FW = 14;
  localparam int OW = 2 * FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fan_mode = 1'b0, half_b = 1'b0;
  logic          cs_p = 1'b1, cs_s = 1'b1;
  logic [DW-1:0] data = '0;
  logic [OW-1:0] q;
  logic          cs_p_o, cs_s_o;

  logic [OW-1:0] q_exp = '0;
  logic          csp_exp = 1'b0, css_exp = 1'b0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  crb_buffer u_crb_buffer (
    .clk_i(clk), .rst_ni(rst_n), .fan_mode_i(fan_mode), .half_b_i(half_b),
    .cs_pri_ni(cs_p), .cs_sec_ni(cs_s), .data_i(data),
    .q_o(q), .cs_pri_no(cs_p_o), .cs_sec_no(cs_s_o)
  );

  function automatic logic [OW-1:0] model(input logic fm, input logic hb, input logic [DW-1:0] d);
    logic [OW-1:0] r = '0;
    for (int i = 0; i < OW; i++) begin
      if (!fm) r[i] = (i < DW) ? d[i] : 1'b0;
      else if (!hb) r[i] = d[i % FW];
      else r[i] = d[DW - FW + (i % FW)];
    end
    return r;
  endfunction

  task automatic chk_q(input string tag, input logic [OW-1:0] exp_v);
    n_chk++;
    if (q !== exp_v) begin
      n_fail++;
      $display("FAIL %s q_o actual=%h expected=%h", tag, q, exp_v);
    end
  endtask

  task automatic chk_cs(input string tag);
    n_chk++;
    if (cs_p_o !== csp_exp || cs_s_o !== css_exp) begin
      n_fail++;
      $display("FAIL %s cs actual=%b%b expected=%b%b", tag, cs_p_o, cs_s_o, csp_exp, css_exp);
    end
  endtask

  task automatic step(input logic [DW-1:0] d, input logic p, input logic s, input string tag);
    @(negedge clk);
    data = d; cs_p = p; cs_s = s;
    @(posedge clk);
    if (!(p && s)) q_exp = model(fan_mode, half_b, d);
    csp_exp = p; css_exp = s;
    #2;
    chk_q(tag, q_exp);
    chk_cs("R7");
  endtask

  // reset mid-cycle, check asynchronously, then apply new straps
  task automatic do_reset(input logic fm, input logic hb);
    @(negedge clk);
    #3 rst_n = 1'b0; cs_p = 1'b1; cs_s = 1'b1;
    #2;
    q_exp = '0; csp_exp = 1'b0; css_exp = 1'b0;
    chk_q("R8", '0);
    chk_cs("R8");
    fan_mode = fm; half_b = hb;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic rp, rs;
    void'($urandom(32'h5eed_c0de));
    repeat (2) @(posedge clk);
    #2;
    chk_q("R8", '0);
    chk_cs("R8");
    @(negedge clk);
    rst_n = 1'b1;

    // direct mode
    step('1, 1'b0, 1'b1, "R2");
    step(25'h0AA_5555, 1'b1, 1'b0, "R1");
    step(25'h155_AAAA, 1'b1, 1'b1, "R5");
    step(25'h000_0001, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 150; k++) begin
      rd = DW'($urandom); rp = $urandom_range(0, 1); rs = $urandom_range(0, 1);
      step(rd, rp, rs, (rp && rs) ? "R5" : "R1");
    end

    // reset while held, then fan-out lower group
    step(25'h1FF_FFFF, 1'b1, 1'b1, "R5");
    do_reset(1'b1, 1'b0);
    step(25'h000_2001, 1'b0, 1'b1, "R3");
    step(25'h1FF_C000, 1'b0, 1'b1, "R3");
    for (int k = 0; k < 150; k++) begin
      rd = DW'($urandom); rp = $urandom_range(0, 1); rs = $urandom_range(0, 1);
      step(rd, rp, rs, (rp && rs) ? "R5" : "R3");
    end

    // fan-out upper group: bit 11 and bit 24 are the ends of the window
    do_reset(1'b1, 1'b1);
    step(25'h000_0800, 1'b1, 1'b0, "R4");
    step(25'h100_0000, 1'b1, 1'b0, "R4");
    step(25'h000_07FF, 1'b0, 1'b1, "R4");
    for (int k = 0; k < 150; k++) begin
      rd = DW'($urandom); rp = $urandom_range(0, 1); rs = $urandom_range(0, 1);
      step(rd, rp, rs, (rp && rs) ? "R5" : "R4");
    end

    // secondary tied low: no hold at all
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 60; k++) begin
      rd = DW'($urandom); rp = $urandom_range(0, 1);
      step(rd, rp, 1'b0, "R9");
    end
    step('1, 1'b1, 1'b0, "R9");

    // reset priority while both selects are high
    step(25'h0F0_F0F0, 1'b1, 1'b1, "R5");
    do_reset(1'b0, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule